// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator

This block maps a 20-bit virtual address onto a 16-bit physical address with 4 KiB pages. A small translation cache is checked first. It holds sixteen entries, arranged as four sets of four ways. When that cache has no entry for the page, a 256-entry page table held in registers supplies the mapping. A valid table entry completes the translation and is copied into the cache. An invalid table entry reports a page fault instead.

A host loads the page table one entry at a time through a write port. The host can also drop every cached translation with a one-cycle flush. The requester raises `req` for one cycle with an address. It then waits for the one-cycle `done` pulse, which arrives with `paddr`, `tlb_hit` and `page_fault`. These three outputs hold their values until the next `done`.

The controller is a three-state machine.
- `S_IDLE`: accepts a request and latches its address.
- `S_LOOKUP`: searches the translation cache.
- `S_WALK`: reads the page table.

Its transitions are:
- `S_IDLE`→`S_LOOKUP` on `req`.
- `S_LOOKUP`→`S_IDLE` on a hit.
- `S_LOOKUP`→`S_WALK` on a miss.
- `S_WALK`→`S_IDLE` always.

Top module: `addr_xlate_unit`

## Requirements
- R1: The virtual page number is `vaddr[19:12]`. The cache set is `vaddr[13:12]` and the cache tag is `vaddr[19:14]`. Pages in different sets never displace one another.
- R2: With `req` sampled at clock edge N, a cache hit raises `done` for one cycle after edge N+1, with `tlb_hit`=1 and `page_fault`=0.
- R3: On every successful translation, `paddr[11:0]` equals `vaddr[11:0]` and `paddr[15:12]` is the 4-bit physical page number.
- R4: On a cache miss whose page-table entry is valid, `done` rises after edge N+2 with `tlb_hit`=0 and `page_fault`=0. The mapping is installed, so the next access to that page hits.
- R5: On a cache miss whose page-table entry is invalid, `done` rises after edge N+2 with `page_fault`=1, `tlb_hit`=0 and `paddr`=0. Nothing is installed.
- R6: An install uses the lowest-numbered invalid way of the set. If the set is full, it replaces the least recently used way. Both a hit and an install make the way the most recently used.
- R7: `done` is a one-cycle pulse. A `req` that arrives while a translation is in flight is ignored and produces no `done`.
- R8: `flush` empties the whole translation cache in one cycle, so every following access misses. The page-table contents are kept.
- R9: Writing a page-table entry (`pt_we`, with `pt_vpn`, `pt_ppn` and `pt_valid`) leaves cached translations untouched. A cached page keeps its old frame until it is flushed or evicted.
- R10: After reset, `done`, `tlb_hit` and `page_fault` are 0 and `paddr` is 0. The cache is empty and every page-table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Translation request strobe |
| vaddr | input | 20 | Virtual address to translate |
| pt_we | input | 1 | Page-table write enable |
| pt_vpn | input | 8 | Page-table entry index |
| pt_ppn | input | 4 | Physical page number to store |
| pt_valid | input | 1 | Valid bit to store |
| flush | input | 1 | Invalidate all cache entries |
| done | output | 1 | Translation complete pulse |
| paddr | output | 16 | Physical address |
| tlb_hit | output | 1 | Translation came from the cache |
| page_fault | output | 1 | Page-table entry was invalid |

## Verification
Some properties are checked by assertions on every cycle:
- At most one way matches in any set.
- The recency ages of each set stay a permutation.
- No hit appears in the cycle after a flush.
- `done` never lasts two cycles.
- A fault never shows a hit or a non-zero address.
- Successful results carry the request's page offset.

Other behaviour only the bench scenarios can show:
- The latency difference between hits and misses.
- Which way a full set evicts after a series of hits.
- Stale mappings surviving a table rewrite.
- Table contents surviving a flush.
- Requests being dropped while the unit is busy.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VA_W  = 20;
    parameter int PA_W  = 16;
    parameter int OFF_W = 12;
    parameter int WAYS  = 4;
    parameter int SETS  = 4;

    localparam int VPN_W   = VA_W - OFF_W;
    localparam int PPN_W   = PA_W - OFF_W;
    localparam int SET_W   = $clog2(SETS);
    localparam int TAG_W   = VPN_W - SET_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int PT_SIZE = 1 << VPN_W;

    typedef struct packed {
        logic             valid;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_WALK   = 2'd2
    } xlat_state_t;
endpackage

// File: rtl/xlat_page_table.sv
module xlat_page_table
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  pte_t             wr_pte,
    input  logic [VPN_W-1:0] rd_vpn,
    output pte_t             rd_pte
);
    pte_t table_q [PT_SIZE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_SIZE; i++) begin
                table_q[i] <= '0;
            end
        end else if (wr_en) begin
            table_q[wr_vpn] <= wr_pte;
        end
    end

    assign rd_pte = table_q[rd_vpn];
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             touch,
    input  logic             fill_en,
    input  logic [PPN_W-1:0] fill_ppn
);
    logic             valid_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
    logic [WAY_W-1:0] age_q   [SETS][WAYS];

    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic             upd_en;
    logic [WAY_W-1:0] upd_way;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
    endgenerate

    always_comb begin
        hit     = |match;
        hit_way = '0;
        hit_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way = WAY_W'(w);
                hit_ppn = ppn_q[lk_set][w];
            end
        end
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_q[lk_set][w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[lk_set][w] == WAY_W'(WAYS - 1)) begin
                    victim = WAY_W'(w);
                end
            end
        end
    end

    assign upd_en  = touch || fill_en;
    assign upd_way = touch ? hit_way : victim;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    tag_q[s][w]   <= '0;
                    ppn_q[s][w]   <= '0;
                    age_q[s][w]   <= WAY_W'(w);
                end
            end
        end else begin
            if (upd_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == upd_way) begin
                        age_q[lk_set][w] <= '0;
                    end else if (age_q[lk_set][w] < age_q[lk_set][upd_way]) begin
                        age_q[lk_set][w] <= age_q[lk_set][w] + 1'b1;
                    end
                end
            end
            if (fill_en) begin
                tag_q[lk_set][victim] <= lk_tag;
                ppn_q[lk_set][victim] <= fill_ppn;
            end
            if (flush) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        valid_q[s][w] <= 1'b0;
                    end
                end
            end else if (fill_en) begin
                valid_q[lk_set][victim] <= 1'b1;
            end
        end
    end

    // Ages within each set must remain a permutation of 0..WAYS-1.
    logic ages_perm;
    always_comb begin
        logic [WAYS-1:0] seen;
        ages_perm = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) begin
                seen[age_q[s][w]] = 1'b1;
            end
            if (seen != '1) ages_perm = 1'b0;
        end
    end

    a_r6_ages_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        ages_perm);

    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             pt_we,
    input  logic [VPN_W-1:0] pt_vpn,
    input  logic [PPN_W-1:0] pt_ppn,
    input  logic             pt_valid,
    input  logic             flush,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic             tlb_hit,
    output logic             page_fault
);
    xlat_state_t      state_q, state_d;
    logic [VA_W-1:0]  vaddr_q;
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] offset;
    logic             c_hit;
    logic [PPN_W-1:0] c_ppn;
    pte_t             walk_pte;

    assign vpn    = vaddr_q[VA_W-1:OFF_W];
    assign offset = vaddr_q[OFF_W-1:0];

    xlat_page_table u_pt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pt_we),
        .wr_vpn (pt_vpn),
        .wr_pte ('{valid: pt_valid, ppn: pt_ppn}),
        .rd_vpn (vpn),
        .rd_pte (walk_pte)
    );

    xlat_tlb u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_set   (vpn[SET_W-1:0]),
        .lk_tag   (vpn[VPN_W-1:SET_W]),
        .hit      (c_hit),
        .hit_ppn  (c_ppn),
        .touch    (state_q == S_LOOKUP && c_hit),
        .fill_en  (state_q == S_WALK && walk_pte.valid),
        .fill_ppn (walk_pte.ppn)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req) state_d = S_LOOKUP;
            S_LOOKUP: state_d = c_hit ? S_IDLE : S_WALK;
            S_WALK:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vaddr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req) vaddr_q <= vaddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            paddr      <= '0;
            tlb_hit    <= 1'b0;
            page_fault <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_LOOKUP: if (c_hit) begin
                    done       <= 1'b1;
                    paddr      <= {c_ppn, offset};
                    tlb_hit    <= 1'b1;
                    page_fault <= 1'b0;
                end
                S_WALK: begin
                    done       <= 1'b1;
                    tlb_hit    <= 1'b0;
                    page_fault <= !walk_pte.valid;
                    paddr      <= walk_pte.valid ? {walk_pte.ppn, offset} : '0;
                end
                default: ;
            endcase
        end
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q) != S_IDLE);

    a_r5_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        page_fault |-> (!tlb_hit && paddr == '0));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !page_fault) |-> paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);
endmodule

// File: tb/addr_xlate_unit_test.sv
module addr_xlate_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] vaddr = '0;
    logic        pt_we = 1'b0;
    logic [7:0]  pt_vpn = '0;
    logic [3:0]  pt_ppn = '0;
    logic        pt_valid = 1'b0;
    logic        flush = 1'b0;
    logic        done;
    logic [15:0] paddr;
    logic        tlb_hit;
    logic        page_fault;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] pa;
        logic        hit;
        logic        fault;
    } exp_t;

    exp_t  sb_q[$];
    string sb_tag[$];

    addr_xlate_unit uut (.*);

    always #10 clk = ~clk;

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R7: unexpected done, actual paddr=%h expected no result", paddr);
            end else begin
                exp_t e;
                string t;
                e = sb_q.pop_front();
                t = sb_tag.pop_front();
                if (paddr !== e.pa || tlb_hit !== e.hit || page_fault !== e.fault) begin
                    errors++;
                    $display("FAIL %s: actual pa=%h hit=%b fault=%b expected pa=%h hit=%b fault=%b",
                             t, paddr, tlb_hit, page_fault, e.pa, e.hit, e.fault);
                end
            end
        end
    end

    task automatic pt_write(input logic [7:0] v, input logic [3:0] p, input logic ok);
        @(negedge clk);
        pt_we = 1'b1; pt_vpn = v; pt_ppn = p; pt_valid = ok;
        @(negedge clk);
        pt_we = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Driver: pushes the expectation, issues the request, checks latency.
    task automatic xlate(input logic [19:0] va, input logic [3:0] ppn, input logic hit,
                         input logic fault, input string tag, input bit poke);
        exp_t e;
        int   cnt;
        int   want;
        e.pa    = fault ? 16'h0 : {ppn, va[11:0]};
        e.hit   = hit;
        e.fault = fault;
        sb_q.push_back(e);
        sb_tag.push_back(tag);
        want = hit ? 2 : 3;
        @(negedge clk);
        req = 1'b1; vaddr = va;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                req = poke;
                vaddr = 20'h41000;
            end else begin
                req = 1'b0;
            end
            if (done) break;
        end
        req = 1'b0;
        checks++;
        if (cnt != want) begin
            errors++;
            $display("FAIL %s: latency actual=%0d expected=%0d", tag, cnt, want);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of the outputs
        checks++;
        if (done !== 1'b0 || tlb_hit !== 1'b0 || page_fault !== 1'b0 || paddr !== 16'h0) begin
            errors++;
            $display("FAIL R10: actual done=%b hit=%b fault=%b pa=%h expected 0 0 0 0000",
                     done, tlb_hit, page_fault, paddr);
        end

        // R10 and R5: table is empty after reset, so the first access faults
        xlate(20'h16A48, 4'h0, 1'b0, 1'b1, "R10", 1'b0);

        pt_write(8'h7E, 4'h8, 1'b1);
        pt_write(8'h02, 4'h1, 1'b1);
        pt_write(8'h06, 4'h2, 1'b1);
        pt_write(8'h0A, 4'h3, 1'b1);
        pt_write(8'h0E, 4'h4, 1'b1);
        pt_write(8'h41, 4'hF, 1'b1);

        xlate(20'h7E37C, 4'h8, 1'b0, 1'b0, "R4", 1'b0);   // cold miss, install
        xlate(20'h7E37C, 4'h8, 1'b1, 1'b0, "R2", 1'b0);   // now a hit: 0x837C
        xlate(20'h16A48, 4'h0, 1'b0, 1'b1, "R5", 1'b0);   // invalid entry
        xlate(20'h16A48, 4'h0, 1'b0, 1'b1, "R5", 1'b0);   // not installed

        // Fill the remaining ways of set 2; a stray request while busy is ignored (R7)
        xlate(20'h02123, 4'h1, 1'b0, 1'b0, "R6", 1'b0);
        xlate(20'h06ABC, 4'h2, 1'b0, 1'b0, "R7", 1'b1);
        xlate(20'h0A001, 4'h3, 1'b0, 1'b0, "R6", 1'b0);
        xlate(20'h7EFFF, 4'h8, 1'b1, 1'b0, "R3", 1'b0);   // max offset
        // Set full: LRU is 0x02
        xlate(20'h0E000, 4'h4, 1'b0, 1'b0, "R6", 1'b0);
        xlate(20'h7E100, 4'h8, 1'b1, 1'b0, "R6", 1'b0);
        xlate(20'h06200, 4'h2, 1'b1, 1'b0, "R6", 1'b0);
        xlate(20'h0A300, 4'h3, 1'b1, 1'b0, "R6", 1'b0);
        xlate(20'h0E400, 4'h4, 1'b1, 1'b0, "R6", 1'b0);
        xlate(20'h02555, 4'h1, 1'b0, 1'b0, "R6", 1'b0);   // evicts 0x7E
        xlate(20'h7E666, 4'h8, 1'b0, 1'b0, "R6", 1'b0);   // evicts 0x06

        // R1: another set does not disturb set 2
        xlate(20'h41FFF, 4'hF, 1'b0, 1'b0, "R1", 1'b0);
        xlate(20'h41FFF, 4'hF, 1'b1, 1'b0, "R1", 1'b0);
        xlate(20'h0A777, 4'h3, 1'b1, 1'b0, "R1", 1'b0);

        // R9: rewriting the table keeps the stale cached frame
        pt_write(8'h0A, 4'hC, 1'b1);
        xlate(20'h0A888, 4'h3, 1'b1, 1'b0, "R9", 1'b0);

        // R8: flush empties the cache, table survives
        do_flush();
        xlate(20'h0A888, 4'hC, 1'b0, 1'b0, "R8", 1'b0);
        xlate(20'h41000, 4'hF, 1'b0, 1'b0, "R8", 1'b0);
        xlate(20'h0E123, 4'h4, 1'b0, 1'b0, "R8", 1'b0);

        repeat (5) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R7: pending results actual=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule